// File: doc/BRIEF.md
# I2C Synthesizer Programming Interface

This block is the write-only register front end of a frequency synthesizer that is configured over I2C. SCL and SDA arrive already synchronized to the system clock. The block answers a seven-bit device address. The upper five bits of that address are a fixed prefix, and the lower two come from a strap input, so four synthesizers can share one bus. After the address byte it accepts any number of data bytes until STOP, with no need to address the device again. From those bytes it decodes a 17-bit divider ratio and a set of control fields: prescaler enable, reference ratio, charge-pump current, crystal enable, crystal select, and four port/test bits.

The data bytes come in pairs. A divider pair is a high byte followed by a low byte. A control pair is a control byte followed by an auxiliary byte. The MSB of the byte that opens a pair selects which pair it is, so the host can program just the divider, just the control fields, or both, in either order. Control fields take effect as soon as their byte has been acknowledged. Divider bits go first into a staging register and reach the active ratio only as a coherent word. That happens once the high, low and control bytes have all arrived since the last update, or when a STOP ends a transfer that carried any divider bits. Because of this, a frequency sweep never passes through a mixed ratio.

Top module: `synth_prog_if`

## Requirements
- R1: After reset every output register reads zero and SDA is released (`sdaLow` = 0).
- R2: An address byte whose bits 7..3 are 11000, bits 2..1 equal `addrSel` and bit 0 is 0 (write) is acknowledged by pulling SDA low during the ninth clock. Any other address, including a read request (bit 0 = 1), is not acknowledged, and the data bytes that follow it leave every output unchanged.
- R3: Every data byte of an addressed write is acknowledged, and `sdaLow` only changes while SCL is low.
- R4: A byte that opens a pair is a divider-high byte when its MSB is 0. Its bits 6..0 become ratio bits 14..8, and the next byte is the divider-low byte, which carries ratio bits 7..0. When the MSB is 1 the byte is a control byte: bits 6..5 become ratio bits 16..15, bit 4 becomes `prescEn` and bits 3..0 become `refRatio`. The next byte is then the auxiliary byte: bits 7..6 go to `pumpCur`, bit 5 to `xtalEnable`, bit 4 to `xtalSelect` and bits 3..0 to `portBits`. After the second byte of either pair, the next byte opens a new pair.
- R5: Control and auxiliary fields update two clocks after the SCL fall that ends their byte's acknowledge, and they do not wait for a STOP.
- R6: The active ratio takes the staged value once divider-high, divider-low and control bytes have all been received since the last update. The staged value includes the byte that completes the set.
- R7: A STOP that follows any divider-bearing byte not yet applied copies the staged ratio to the active ratio.
- R8: Divider-high and divider-low bytes sent repeatedly, with no control byte and no STOP, leave the active ratio unchanged.
- R9: A START or repeated START makes the next byte an address byte and makes the first data byte after it open a pair. A STOP returns the block to idle.
- R10: The active ratio changes only on the cycle after a divider write or a STOP event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| scl | input | 1 | Synchronized I2C clock |
| sda | input | 1 | Synchronized I2C data (bus level) |
| addrSel | input | 2 | Low two bits of the device address |
| sdaLow | output | 1 | Pull SDA low (acknowledge) |
| divRatio | output | 17 | Active divider ratio |
| prescEn | output | 1 | Prescaler enable |
| refRatio | output | 4 | Reference divider select |
| pumpCur | output | 2 | Charge-pump current select |
| xtalEnable | output | 1 | Crystal oscillator enable |
| xtalSelect | output | 1 | Crystal select |
| portBits | output | 4 | Port / test bits |

## Verification
The control byte can do two things in one clock. It writes the prescaler and reference fields, and it can also be the byte that completes the divider set, so the staging write and the commit to the active ratio fall in the same cycle. The 2,3,4,5 and 4,5,2,3 sequences provoke this: in the first the closing byte is a control byte, and in the second the closing byte is a divider byte that merges with bits staged earlier. A behavioural model compares the ratio each cycle and expects it to contain the bits of the closing byte. A STOP arriving while bytes are pending is checked the same way, against fixed expected ratios.

// File: rtl/synth_prog_pkg.sv
package synth_prog_pkg;
  localparam int BYTE_W   = 8;
  localparam int SEL_W    = 2;
  localparam int PREFIX_W = BYTE_W - 1 - SEL_W;
  localparam int DIV_W    = 17;
  localparam int HI_W     = 7;
  localparam int LO_W     = 8;
  localparam int TOP_W    = DIV_W - HI_W - LO_W;
  localparam int REF_W    = 4;
  localparam int PUMP_W   = 2;
  localparam int PORT_W   = 4;
  localparam int CNT_W    = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_ADDR, BUS_ACK_ADDR, BUS_DATA, BUS_ACK_DATA, BUS_SKIP
  } bus_state_t;

  typedef enum logic [1:0] {
    SLOT_OPEN, SLOT_LOW, SLOT_AUX
  } slot_t;

  typedef struct packed {
    logic              wrHi;
    logic              wrLo;
    logic              wrCtl;
    logic              wrAux;
    logic              busStop;
    logic [BYTE_W-1:0] data;
  } prog_strobe_t;
endpackage

// File: rtl/synth_prog_ctrl.sv
module synth_prog_ctrl
  import synth_prog_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             scl,
  input  logic             sda,
  input  logic [SEL_W-1:0] addrSel,
  output logic             sdaLow,
  output prog_strobe_t     strb
);
  bus_state_t        state;
  slot_t             slot;
  slot_t             slotNext;
  logic [CNT_W-1:0]  bitCnt;
  logic [BYTE_W-1:0] shiftReg;
  logic              sclQ;
  logic              sdaQ;
  logic              sclRise;
  logic              sclFall;
  logic              startEvt;
  logic              stopEvt;
  logic              addrHit;
  logic              byteFull;
  prog_strobe_t      dataStrobe;

  assign sclRise  = scl && !sclQ;
  assign sclFall  = !scl && sclQ;
  assign startEvt = scl && sclQ && sdaQ && !sda;
  assign stopEvt  = scl && sclQ && !sdaQ && sda;
  assign byteFull = (bitCnt == CNT_W'(BYTE_W));
  assign addrHit  = (shiftReg[BYTE_W-1:1] == {ADDR_PREFIX, addrSel}) && !shiftReg[0];

  always_comb begin
    dataStrobe      = '0;
    dataStrobe.data = shiftReg;
    slotNext        = SLOT_OPEN;
    unique case (slot)
      SLOT_LOW: dataStrobe.wrLo  = 1'b1;
      SLOT_AUX: dataStrobe.wrAux = 1'b1;
      default: begin
        if (shiftReg[BYTE_W-1]) begin
          dataStrobe.wrCtl = 1'b1;
          slotNext         = SLOT_AUX;
        end else begin
          dataStrobe.wrHi  = 1'b1;
          slotNext         = SLOT_LOW;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= BUS_IDLE;
      slot     <= SLOT_OPEN;
      bitCnt   <= '0;
      shiftReg <= '0;
      sclQ     <= 1'b1;
      sdaQ     <= 1'b1;
      sdaLow   <= 1'b0;
      strb     <= '0;
    end else begin
      sclQ <= scl;
      sdaQ <= sda;
      strb <= '0;
      if (stopEvt) begin
        state        <= BUS_IDLE;
        sdaLow       <= 1'b0;
        strb.busStop <= 1'b1;
      end else if (startEvt) begin
        state  <= BUS_ADDR;
        slot   <= SLOT_OPEN;
        bitCnt <= '0;
        sdaLow <= 1'b0;
      end else begin
        unique case (state)
          BUS_ADDR, BUS_DATA: begin
            if (sclRise && !byteFull) begin
              shiftReg <= {shiftReg[BYTE_W-2:0], sda};
              bitCnt   <= bitCnt + 1'b1;
            end else if (sclFall && byteFull) begin
              if (state == BUS_DATA) begin
                sdaLow <= 1'b1;
                state  <= BUS_ACK_DATA;
              end else if (addrHit) begin
                sdaLow <= 1'b1;
                state  <= BUS_ACK_ADDR;
              end else begin
                state  <= BUS_SKIP;
              end
            end
          end
          BUS_ACK_ADDR: begin
            if (sclFall) begin
              sdaLow <= 1'b0;
              bitCnt <= '0;
              state  <= BUS_DATA;
            end
          end
          BUS_ACK_DATA: begin
            if (sclFall) begin
              sdaLow <= 1'b0;
              bitCnt <= '0;
              state  <= BUS_DATA;
              strb   <= dataStrobe;
              slot   <= slotNext;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_prog_regs.sv
module synth_prog_regs
  import synth_prog_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  prog_strobe_t      strb,
  output logic [DIV_W-1:0]  divRatio,
  output logic              prescEn,
  output logic [REF_W-1:0]  refRatio,
  output logic [PUMP_W-1:0] pumpCur,
  output logic              xtalEnable,
  output logic              xtalSelect,
  output logic [PORT_W-1:0] portBits
);
  localparam int GOT_N = 3;

  logic [DIV_W-1:0] stage;
  logic [DIV_W-1:0] stageNext;
  logic [GOT_N-1:0] got;
  logic [GOT_N-1:0] gotNext;
  logic             commitNow;

  always_comb begin
    stageNext = stage;
    gotNext   = got;
    if (strb.wrHi) begin
      stageNext[LO_W +: HI_W] = strb.data[HI_W-1:0];
      gotNext[0] = 1'b1;
    end
    if (strb.wrLo) begin
      stageNext[LO_W-1:0] = strb.data;
      gotNext[1] = 1'b1;
    end
    if (strb.wrCtl) begin
      stageNext[DIV_W-1 -: TOP_W] = strb.data[BYTE_W-2 -: TOP_W];
      gotNext[2] = 1'b1;
    end
    commitNow = (&gotNext) || (strb.busStop && (|got));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stage      <= '0;
      got        <= '0;
      divRatio   <= '0;
      prescEn    <= 1'b0;
      refRatio   <= '0;
      pumpCur    <= '0;
      xtalEnable <= 1'b0;
      xtalSelect <= 1'b0;
      portBits   <= '0;
    end else begin
      stage <= stageNext;
      got   <= commitNow ? '0 : gotNext;
      if (commitNow) divRatio <= stageNext;
      if (strb.wrCtl) begin
        prescEn  <= strb.data[REF_W];
        refRatio <= strb.data[REF_W-1:0];
      end
      if (strb.wrAux) begin
        pumpCur    <= strb.data[BYTE_W-1 -: PUMP_W];
        xtalEnable <= strb.data[PORT_W+1];
        xtalSelect <= strb.data[PORT_W];
        portBits   <= strb.data[PORT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/synth_prog_if.sv
module synth_prog_if
  import synth_prog_pkg::*;
#(
  parameter logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b11000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              scl,
  input  logic              sda,
  input  logic [SEL_W-1:0]  addrSel,
  output logic              sdaLow,
  output logic [DIV_W-1:0]  divRatio,
  output logic              prescEn,
  output logic [REF_W-1:0]  refRatio,
  output logic [PUMP_W-1:0] pumpCur,
  output logic              xtalEnable,
  output logic              xtalSelect,
  output logic [PORT_W-1:0] portBits
);
  prog_strobe_t progStrobe;

  synth_prog_ctrl #(.ADDR_PREFIX(ADDR_PREFIX)) ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .scl     (scl),
    .sda     (sda),
    .addrSel (addrSel),
    .sdaLow  (sdaLow),
    .strb    (progStrobe)
  );

  synth_prog_regs regs (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (progStrobe),
    .divRatio   (divRatio),
    .prescEn    (prescEn),
    .refRatio   (refRatio),
    .pumpCur    (pumpCur),
    .xtalEnable (xtalEnable),
    .xtalSelect (xtalSelect),
    .portBits   (portBits)
  );
endmodule

// File: rtl/synth_prog_chk.sv
module synth_prog_chk
  import synth_prog_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              scl,
  input logic              sdaLow,
  input logic              wrHi,
  input logic              wrLo,
  input logic              wrCtl,
  input logic              wrAux,
  input logic              busStop,
  input logic [DIV_W-1:0]  divRatio,
  input logic              prescEn,
  input logic [REF_W-1:0]  refRatio,
  input logic [PUMP_W-1:0] pumpCur,
  input logic [PORT_W-1:0] portBits
);
  // R10: the active ratio moves only after a divider write or a STOP
  a_r10_div_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wrHi || wrLo || wrCtl || busStop) |=> $stable(divRatio));

  // R3: acknowledge drive is applied and released only while SCL is low
  a_r3_ack_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaLow) |-> !scl);
  a_r3_release_on_low: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaLow) |-> !scl);

  // R4: each data byte lands in exactly one slot
  a_r4_one_slot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({wrHi, wrLo, wrCtl, wrAux}));

  // R5: control fields move only on a control-byte write
  a_r5_ctl_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrCtl |=> ($stable(refRatio) && $stable(prescEn)));

  // R5: auxiliary fields move only on an auxiliary-byte write
  a_r5_aux_hold: assert property (@(posedge clk) disable iff (!rstN)
    !wrAux |=> ($stable(pumpCur) && $stable(portBits)));
endmodule

bind synth_prog_if synth_prog_chk chk (
  .clk      (clk),
  .rstN     (rstN),
  .scl      (scl),
  .sdaLow   (sdaLow),
  .wrHi     (progStrobe.wrHi),
  .wrLo     (progStrobe.wrLo),
  .wrCtl    (progStrobe.wrCtl),
  .wrAux    (progStrobe.wrAux),
  .busStop  (progStrobe.busStop),
  .divRatio (divRatio),
  .prescEn  (prescEn),
  .refRatio (refRatio),
  .pumpCur  (pumpCur),
  .portBits (portBits)
);

// File: tb/synth_prog_if_test.sv
module synth_prog_if_test;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD       = 3;
  localparam int WATCHDOG   = 150000;

  logic        clk  = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic [1:0]  sel  = 2'b10;
  logic        sdaBus;
  logic        sdaLow;
  logic [16:0] divRatio;
  logic        prescEn;
  logic [3:0]  refRatio;
  logic [1:0]  pumpCur;
  logic        xtalEnable;
  logic        xtalSelect;
  logic [3:0]  portBits;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // reference model state
  logic [16:0] mDiv = '0, mStage = '0;
  logic        mPresc = 0, mXce = 0, mXcs = 0, mAck = 0, mAddrOk = 0;
  logic [3:0]  mRef = '0, mPort = '0;
  logic [1:0]  mPump = '0;
  int          mNext = 0;
  int          pend[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaBus = sdaM & ~sdaLow;

  synth_prog_if uut (
    .clk(clk), .rstN(rstN), .scl(sclM), .sda(sdaBus), .addrSel(sel),
    .sdaLow(sdaLow), .divRatio(divRatio), .prescEn(prescEn),
    .refRatio(refRatio), .pumpCur(pumpCur), .xtalEnable(xtalEnable),
    .xtalSelect(xtalSelect), .portBits(portBits)
  );

  task automatic checkVal(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit pendHas(input int id);
    foreach (pend[i]) if (pend[i] == id) return 1'b1;
    return 1'b0;
  endfunction

  task automatic modelByte(input logic [7:0] b);
    int kind;
    kind = (mNext == 0) ? (b[7] ? 4 : 2) : mNext;
    case (kind)
      2: begin mStage[14:8] = b[6:0]; mNext = 3; pend.push_back(2); end
      3: begin mStage[7:0] = b; mNext = 0; pend.push_back(3); end
      4: begin
        mStage[16:15] = b[6:5]; mPresc = b[4]; mRef = b[3:0];
        mNext = 5; pend.push_back(4);
      end
      default: begin
        mPump = b[7:6]; mXce = b[5]; mXcs = b[4]; mPort = b[3:0]; mNext = 0;
      end
    endcase
    if (pendHas(2) && pendHas(3) && pendHas(4)) begin
      mDiv = mStage;
      pend.delete();
    end
  endtask

  // per-cycle comparison against the model (R10 and all fields)
  always @(negedge clk) begin
    if (rstN && !done) begin
      checkVal("R10 model divRatio", 32'(divRatio), 32'(mDiv));
      checkVal("R5 model prescEn", 32'(prescEn), 32'(mPresc));
      checkVal("R5 model refRatio", 32'(refRatio), 32'(mRef));
      checkVal("R5 model pumpCur", 32'(pumpCur), 32'(mPump));
      checkVal("R5 model xtal", 32'({xtalEnable, xtalSelect}), 32'({mXce, mXcs}));
      checkVal("R5 model portBits", 32'(portBits), 32'(mPort));
      checkVal("R3 model sdaLow", 32'(sdaLow), 32'(mAck));
    end
  end

  task automatic drive(input logic s, input logic d);
    @(negedge clk);
    sclM = s;
    sdaM = d;
  endtask

  task automatic hold();
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic busStart();
    drive(1'b1, 1'b1); hold();
    drive(1'b1, 1'b0); hold();
    drive(1'b0, 1'b0); hold();
    mNext = 0; mAddrOk = 0;
  endtask

  task automatic busRestart();
    drive(1'b0, 1'b1); hold();
    drive(1'b1, 1'b1); hold();
    drive(1'b1, 1'b0); hold();
    drive(1'b0, 1'b0); hold();
    mNext = 0; mAddrOk = 0;
  endtask

  task automatic busStop();
    drive(1'b0, 1'b0); hold();
    drive(1'b1, 1'b0); hold();
    drive(1'b1, 1'b1);
    @(posedge clk); @(posedge clk);
    if (pend.size() > 0) begin
      mDiv = mStage;
      pend.delete();
    end
    mAddrOk = 0;
    hold();
  endtask

  task automatic sendByte(input logic [7:0] b, input bit isAddr);
    logic willAck;
    if (isAddr) mAddrOk = (b == {5'b11000, sel, 1'b0});
    willAck = mAddrOk;
    for (int i = 7; i >= 0; i--) begin
      drive(1'b0, b[i]); hold();
      drive(1'b1, b[i]); hold();
      drive(1'b0, b[i]);
      if (i == 0) begin
        @(posedge clk);
        mAck = willAck;
      end
      hold();
    end
    drive(1'b0, 1'b1); hold();
    drive(1'b1, 1'b1); hold();
    checkVal(isAddr ? "R2 address acknowledge" : "R3 data acknowledge",
             32'(!sdaBus), 32'(willAck));
    drive(1'b0, 1'b1);
    @(posedge clk);
    mAck = 1'b0;
    @(posedge clk);
    if (!isAddr && willAck) modelByte(b);
    hold();
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R9 actual hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] adr;
    adr = {5'b11000, sel, 1'b0};
    repeat (5) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    hold();
    // R1: reset state
    checkVal("R1 divRatio reset", 32'(divRatio), 32'h0);
    checkVal("R1 control reset", 32'({prescEn, refRatio, pumpCur, xtalEnable, xtalSelect, portBits}), 32'h0);
    checkVal("R1 sda released", 32'(sdaLow), 32'h0);

    // 2,3,4,5 : commit when the control byte completes the set
    busStart(); sendByte(adr, 1);
    sendByte(8'h12, 0); sendByte(8'h34, 0);
    checkVal("R6 no commit before control byte", 32'(divRatio), 32'h0);
    sendByte(8'hB5, 0);
    checkVal("R6 commit on 2,3,4", 32'(divRatio), 32'h09234);
    checkVal("R4 control decode", 32'({prescEn, refRatio}), 32'h15);
    sendByte(8'hAC, 0);
    checkVal("R4 aux decode", 32'({pumpCur, xtalEnable, xtalSelect, portBits}), 32'hAC);
    busStop();

    // 4,5,2,3
    busStart(); sendByte(adr, 1);
    sendByte(8'hC0, 0);
    checkVal("R5 control applied before STOP", 32'({prescEn, refRatio}), 32'h0);
    checkVal("R6 ratio held after control only", 32'(divRatio), 32'h09234);
    sendByte(8'h41, 0); sendByte(8'h01, 0);
    checkVal("R6 ratio held before low byte", 32'(divRatio), 32'h09234);
    sendByte(8'hFF, 0);
    checkVal("R6 commit on 4,5,2,3", 32'(divRatio), 32'h101FF);
    busStop();

    // 2,3,4,STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'h7F, 0); sendByte(8'h00, 0); sendByte(8'h8A, 0);
    checkVal("R6 commit on 2,3,4 before STOP", 32'(divRatio), 32'h07F00);
    checkVal("R4 reference field", 32'(refRatio), 32'hA);
    busStop();

    // 4,5,2,STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'hE3, 0); sendByte(8'h00, 0); sendByte(8'h05, 0);
    checkVal("R7 held until STOP", 32'(divRatio), 32'h07F00);
    busStop();
    checkVal("R7 commit on 4,5,2,STOP", 32'(divRatio), 32'h18500);

    // 2,3,STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'h00, 0); sendByte(8'h2A, 0); busStop();
    checkVal("R7 commit on 2,3,STOP", 32'(divRatio), 32'h1802A);

    // 2,STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'h40, 0); busStop();
    checkVal("R7 commit on 2,STOP", 32'(divRatio), 32'h1C02A);

    // 4,STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'h80, 0); busStop();
    checkVal("R7 commit on 4,STOP", 32'(divRatio), 32'h0402A);

    // 2,3,2,3 with no STOP
    busStart(); sendByte(adr, 1);
    sendByte(8'h11, 0); sendByte(8'h22, 0); sendByte(8'h33, 0); sendByte(8'h44, 0);
    checkVal("R8 repeated divider pairs hold ratio", 32'(divRatio), 32'h0402A);
    busStop();
    checkVal("R7 STOP after repeated pairs", 32'(divRatio), 32'h03344);

    // foreign address, then a read request
    busStart(); sendByte({5'b11000, 2'b01, 1'b0}, 1);
    sendByte(8'h9F, 0);
    checkVal("R2 foreign address ignored", 32'({prescEn, refRatio}), 32'h0);
    busStop();
    busStart(); sendByte({5'b11000, sel, 1'b1}, 1);
    sendByte(8'h9F, 0);
    checkVal("R2 read request ignored", 32'({prescEn, refRatio}), 32'h0);
    busStop();
    checkVal("R2 ratio untouched", 32'(divRatio), 32'h03344);

    // repeated START resets the pair pointer
    busStart(); sendByte(adr, 1);
    sendByte(8'h01, 0);
    busRestart(); sendByte(adr, 1);
    sendByte(8'h85, 0);
    checkVal("R9 byte after repeated START opens a pair", 32'(refRatio), 32'h5);
    busStop();
    checkVal("R9 STOP commit after repeated START", 32'(divRatio), 32'h00144);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule